// File: doc/BRIEF.md
# Zero-Cross Synchronized Settings Update Controller

This block sits between a serial control receiver and the analog switch bank of an audio signal path. Each received transfer arrives as a settings word, a two-bit update-mode code and a two-bit detection-source code. A one-cycle load strobe marks the moment the transfer ends. In gated mode the settings word is held pending and is released only when the chosen audio stage reports a zero crossing. Switching the analog network at that instant keeps switching noise low. If no crossing comes, a timeout releases the word anyway. In immediate mode the word is released at once on the load strobe.

The mode and source codes are not held back. They take effect at the load strobe itself. This lets one transfer pick the mode, choose which stage's crossing to wait for, and carry the new settings. The released word appears on a registered output together with a one-cycle commit strobe. The analog comparators are outside this block, and each one delivers a one-cycle pulse per crossing.

Top module: `zc_update_ctrl`

## Requirements
- R1: After reset, pending_o and commit_o are 0, data_o equals RESET_WORD (0 by default), gated_o is 1 and src_o is 0.
- R2: A load with mode_i = 2'b00 (gated) stores the word. In the next cycle pending_o is 1, commit_o is 0 and data_o is unchanged.
- R3: A load with any other mode_i code (2'b11, and also 2'b01 or 2'b10) sets commit_o and data_o = word_i in the next cycle. It also clears any pending word.
- R4: At every load, src_o takes src_sel_i and gated_o takes (mode_i == 2'b00) in the next cycle, whatever the mode. Source codes map to zc_i bits: 0 selector (zc_i[0]), 1 volume (zc_i[1]), 2 tone (zc_i[2]), 3 fader (zc_i[3]).
- R5: While a word is pending, a pulse on zc_i[src_o] sampled at a clock edge commits it at that edge. commit_o is high and data_o holds the pending word in the following cycle.
- R6: While a word is pending, pulses on zc_i bits other than the selected one have no effect.
- R7: With no selected pulse, a pending word commits exactly TIMEOUT_CYC clock edges after its load edge. pending_o stays high for exactly TIMEOUT_CYC cycles.
- R8: A gated load while another word is pending replaces that word and restarts the timeout. Only the newer word is ever committed.
- R9: Each transfer produces exactly one commit_o pulse of one cycle. data_o changes only together with commit_o, and pending_o is 0 whenever commit_o is 1.
- R10: A zc_i pulse in the same cycle as a gated load does not commit the new word.
- R11: zc_i pulses while nothing is pending produce no commit and leave data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe: transfer finished, word and codes valid |
| word_i | input | DATA_W | Settings word of the transfer |
| mode_i | input | 2 | Update mode code, 2'b00 gated, others immediate |
| src_sel_i | input | 2 | Detection-source code: 0 selector, 1 volume, 2 tone, 3 fader |
| zc_i | input | 4 | Zero-crossing pulses, one bit per stage |
| commit_o | output | 1 | One-cycle strobe: data_o just took a new word |
| data_o | output | DATA_W | Committed settings word |
| pending_o | output | 1 | A gated word is waiting for release |
| gated_o | output | 1 | Latched mode: 1 when the last transfer asked for gating |
| src_o | output | 2 | Latched detection-source code |

## Verification
The assertions check on every cycle that each load reacts correctly in the next cycle for its mode, and that the latched source code follows the transfer. They also check that a selected crossing during a pending word always commits it, that unselected crossings keep it pending, that the timeout counter stays in range, and that data_o never moves without a commit strobe. Only the bench's scenarios can show the cycle on which a commit lands relative to the load for each source, and that the timeout fires at exactly TIMEOUT_CYC. The scenarios also show that a replaced word is never released and that the released word is the right one out of a sequence.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_W   = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_SELECTOR = 2'd0,
    SRC_VOLUME   = 2'd1,
    SRC_TONE     = 2'd2,
    SRC_FADER    = 2'd3
  } zc_src_e;

  localparam logic [1:0] MODE_GATED = 2'b00;

  function automatic logic mode_is_gated(input logic [1:0] mode);
    return mode == MODE_GATED;
  endfunction
endpackage

// File: rtl/zc_src_mux.sv
module zc_src_mux #(
  parameter int NUM_SRC = zc_pkg::NUM_SRC,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] zc_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);
  logic [NUM_SRC-1:0] sel_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign sel_hit[g] = zc_i[g] && (sel_i == SEL_W'(g));
  end

  assign hit_o = |sel_hit;
endmodule

// File: rtl/zc_timeout.sv
module zc_timeout #(
  parameter int TIMEOUT_CYC = 1_250_000,
  localparam int CNT_W      = $clog2(TIMEOUT_CYC) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && !restart_i && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (!expire_o)   cnt_q <= cnt_q + 1'b1;
  end

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TIMEOUT_CYC));

  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/zc_ctrl_latch.sv
module zc_ctrl_latch
  import zc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic [SRC_W-1:0] src_sel_i,
  output logic             gated_o,
  output logic [SRC_W-1:0] src_o
);
  // control codes bypass the zero-cross wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gated_o <= 1'b1;
      src_o   <= SRC_SELECTOR;
    end else if (load_i) begin
      gated_o <= mode_is_gated(mode_i);
      src_o   <= src_sel_i;
    end
  end

  a_r4_src_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (src_o == $past(src_sel_i)) && (gated_o == ($past(mode_i) == 2'b00)));

  a_r4_src_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(src_o) && $stable(gated_o));
endmodule

// File: rtl/zc_word_stage.sv
module zc_word_stage #(
  parameter int               DATA_W     = 44,
  parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              gated_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              fire_i,
  output logic              pending_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= RESET_WORD;
      pending_o <= 1'b0;
      commit_o  <= 1'b0;
      data_o    <= RESET_WORD;
    end else if (load_i) begin
      // new transfer wins over any crossing in the same cycle
      if (gated_i) begin
        hold_q    <= word_i;
        pending_o <= 1'b1;
        commit_o  <= 1'b0;
      end else begin
        data_o    <= word_i;
        pending_o <= 1'b0;
        commit_o  <= 1'b1;
      end
    end else if (pending_o && fire_i) begin
      data_o    <= hold_q;
      pending_o <= 1'b0;
      commit_o  <= 1'b1;
    end else begin
      commit_o  <= 1'b0;
    end
  end

  a_r2_gated_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && gated_i |=> pending_o && !commit_o && $stable(data_o));

  a_r3_imm_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !gated_i |=> commit_o && !pending_o && (data_o == $past(word_i)));

  a_r9_commit_not_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !pending_o);

  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> $stable(data_o));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_o && !load_i |=> !commit_o);
endmodule

// File: rtl/zc_update_ctrl.sv
module zc_update_ctrl
  import zc_pkg::*;
#(
  parameter int                DATA_W      = 44,
  parameter int                TIMEOUT_CYC = 1_250_000,
  parameter logic [DATA_W-1:0] RESET_WORD  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        src_sel_i,
  input  logic [3:0]        zc_i,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pending_o,
  output logic              gated_o,
  output logic [1:0]        src_o
);
  logic zc_hit;
  logic expire;
  logic fire;
  logic gated_new;

  assign gated_new = mode_is_gated(mode_i);
  assign fire      = zc_hit || expire;

  zc_ctrl_latch u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .mode_i    (mode_i),
    .src_sel_i (src_sel_i),
    .gated_o   (gated_o),
    .src_o     (src_o)
  );

  zc_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .zc_i  (zc_i),
    .sel_i (src_o),
    .hit_o (zc_hit)
  );

  zc_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .run_i     (pending_o),
    .expire_o  (expire)
  );

  zc_word_stage #(.DATA_W(DATA_W), .RESET_WORD(RESET_WORD)) u_word (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .gated_i   (gated_new),
    .word_i    (word_i),
    .fire_i    (fire),
    .pending_o (pending_o),
    .commit_o  (commit_o),
    .data_o    (data_o)
  );

  a_r5_hit_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && !load_i && zc_i[src_o] |=> commit_o);

  a_r6_other_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && !load_i && !zc_i[src_o] && !expire |=> pending_o && !commit_o);

  a_r10_load_beats_zc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && gated_new |=> !commit_o);
endmodule

// File: tb/tb_zc_update_ctrl.sv
module tb_zc_update_ctrl;
  localparam int DW = 16;
  localparam int TO = 40;
  localparam int NV = 10;

  typedef struct packed {
    logic [1:0]    mode;
    logic [1:0]    src;
    logic [DW-1:0] word;
    logic [7:0]    pulse_at;
    logic [1:0]    pulse_src;
    logic [7:0]    exp_n;
  } vec_t;

  // exp_n: negedge index after the load on which commit_o is first seen
  localparam vec_t VEC [NV] = '{
    '{2'b11, 2'd0, 16'hA1A1, 8'd0,  2'd0, 8'd1},
    '{2'b00, 2'd0, 16'hB202, 8'd5,  2'd0, 8'd6},
    '{2'b00, 2'd1, 16'hC303, 8'd3,  2'd1, 8'd4},
    '{2'b00, 2'd2, 16'hD404, 8'd10, 2'd2, 8'd11},
    '{2'b00, 2'd3, 16'hE505, 8'd1,  2'd3, 8'd2},
    '{2'b00, 2'd1, 16'h1606, 8'd4,  2'd2, 8'd41},
    '{2'b00, 2'd2, 16'h2707, 8'd0,  2'd0, 8'd41},
    '{2'b01, 2'd3, 16'h3808, 8'd0,  2'd0, 8'd1},
    '{2'b10, 2'd0, 16'h4909, 8'd0,  2'd0, 8'd1},
    '{2'b00, 2'd3, 16'h5A0A, 8'd39, 2'd3, 8'd40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [DW-1:0] word = '0;
  logic [1:0] mode = '0;
  logic [1:0] src_sel = '0;
  logic [3:0] zc = '0;
  logic commit;
  logic [DW-1:0] data;
  logic pending;
  logic gated;
  logic [1:0] src;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zc_update_ctrl #(.DATA_W(DW), .TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .word_i(word), .mode_i(mode),
    .src_sel_i(src_sel), .zc_i(zc), .commit_o(commit), .data_o(data),
    .pending_o(pending), .gated_o(gated), .src_o(src)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge (n=1)
  task automatic do_load(input logic [1:0] m, input logic [1:0] s, input logic [DW-1:0] w,
                         input logic [3:0] zv);
    load = 1'b1; mode = m; src_sel = s; word = w; zc = zv;
    @(negedge clk);
    load = 1'b0; zc = '0;
  endtask

  task automatic observe(input int p, input logic [1:0] ps, input logic [DW-1:0] w,
                         input int exp_n, input string req);
    int first = 0;
    int cnt = 0;
    for (int n = 1; n <= TO + 3; n++) begin
      if (commit) begin
        cnt++;
        if (first == 0) first = n;
        chk(data == w, {req, " committed word"}, 32'(data), 32'(w));
      end
      zc = (n == p) ? (4'b0001 << ps) : 4'b0000;
      @(negedge clk);
    end
    zc = '0;
    chk(first == exp_n, {req, " commit cycle"}, 32'(first), 32'(exp_n));
    chk(cnt == 1, "R9 one commit per transfer", 32'(cnt), 32'd1);
    chk(!pending, {req, " pending cleared"}, 32'(pending), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!pending && !commit, "R1 flags at reset", {30'd0, pending, commit}, 32'd0);
    chk(data == '0, "R1 data at reset", 32'(data), 32'd0);
    chk(gated && src == 2'd0, "R1 codes at reset", {29'd0, gated, src}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i].mode, VEC[i].src, VEC[i].word, 4'b0000);
      chk(src == VEC[i].src, "R4 source latched", 32'(src), 32'(VEC[i].src));
      chk(gated == (VEC[i].mode == 2'b00), "R4 mode latched", 32'(gated),
          32'(VEC[i].mode == 2'b00));
      if (VEC[i].mode == 2'b00)
        chk(pending && !commit, "R2 gated load pends", {30'd0, pending, commit}, 32'h2);
      observe(int'(VEC[i].pulse_at), VEC[i].pulse_src, VEC[i].word, int'(VEC[i].exp_n),
              (VEC[i].mode != 2'b00) ? "R3" :
              (VEC[i].exp_n == 8'd41) ? ((VEC[i].pulse_at != 0) ? "R6" : "R7") : "R5");
    end

    // R8 replacement restarts the timeout
    begin
      bit early = 1'b0;
      do_load(2'b00, 2'd0, 16'h0111, 4'b0000);
      for (int k = 0; k < 19; k++) begin
        if (commit) early = 1'b1;
        @(negedge clk);
      end
      chk(!early, "R8 no early commit", 32'(early), 32'd0);
      do_load(2'b00, 2'd0, 16'h0222, 4'b0000);
      observe(0, 2'd0, 16'h0222, TO + 1, "R8");
    end

    // R10 crossing in the load cycle is not taken
    do_load(2'b00, 2'd1, 16'h0333, 4'b0010);
    chk(!commit && pending, "R10 same-cycle pulse ignored", {30'd0, commit, pending}, 32'h1);
    observe(3, 2'd1, 16'h0333, 4, "R10");

    // R3 immediate load overrides a pending word
    do_load(2'b00, 2'd2, 16'h0444, 4'b0000);
    repeat (4) @(negedge clk);
    do_load(2'b11, 2'd2, 16'h0555, 4'b0000);
    observe(0, 2'd0, 16'h0555, 1, "R3 override");

    // R11 crossings while idle
    begin
      bit seen = 1'b0;
      zc = 4'b1111;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (commit) seen = 1'b1;
      end
      zc = '0;
      @(negedge clk);
      chk(!seen && !pending, "R11 idle pulses", {30'd0, seen, pending}, 32'd0);
      chk(data == 16'h0555, "R11 data kept", 32'(data), 32'h0555);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule